// File: doc/BRIEF.md
# Snoop Responder with Modified-Line Write-Back

This block is the processor-side bus agent that answers snoops from another bus master while the processor has handed the bus away. The system asks for the bus on `hold_req`. The block grants it on `hold_ack`. While the grant stands, the other master presents a snoop on `snoop_valid`, together with a line index and an invalidate flag. The flag is low when the snoop comes from a read and high when it comes from a write.

The block looks the line up in a small table of line states. If the line is modified, it pulls `hitm_n` low. It then waits for the system to withdraw `hold_req` and takes the bus back. It writes the line out as a four-beat burst, then releases `hitm_n` and grants the bus again.

Lines that are not modified are downgraded in place, and the grant is not disturbed. The processor core installs line states through a fill port. It reads them back through a combinational probe port.

Top module: `snoop_wb_responder`

## Requirements
- R1: After reset, `hold_ack` is 0, `hitm_n`, `ads_n`, `cache_n` and `blast_n` are 1, `wr` is 0, and every line reads invalid. The line-state encoding is 2'b00 invalid, 2'b01 shared, 2'b10 exclusive and 2'b11 modified.
- R2: When no snoop is in progress, `hold_ack` follows `hold_req` with one cycle of delay, both when it rises and when it falls.
- R3: A snoop strobe is taken only in a cycle where `hold_ack` is 1 and was also 1 in the previous cycle. Any other strobe changes neither `hitm_n` nor any line state.
- R4: For a strobe taken in cycle n that hits a modified line, `hitm_n` goes low in cycle n+2.
- R5: A strobe that hits an invalid, shared or exclusive line leaves `hitm_n` at 1 and `hold_ack` at 1. With the invalidate flag at 1, a valid line becomes invalid. With the flag at 0, an exclusive line becomes shared.
- R6: After a modified hit, `hold_ack` stays 1 until `hold_req` is seen low. In the next cycle `hold_ack` is 0, and `ads_n` and `cache_n` are 0 for exactly one cycle with `wr` at 1.
- R7: After that address cycle come four data beats with `wr` at 1. A beat ends only in a cycle where `rdy_n` is 0. `wb_beat` gives the beat number 0 to 3, and `blast_n` is 0 only during beat 3.
- R8: `hitm_n` returns to 1 in the cycle after the one where `blast_n` and `rdy_n` are both 0. Strobes between the hit and that cycle are ignored.
- R9: `hold_ack` rises again no earlier than the second cycle after the final beat. It rises exactly then if `hold_req` is 1 in the cycle after the final beat.
- R10: After the write-back, the line reads shared if the snoop's invalidate flag was 0 and invalid if it was 1.
- R11: A fill writes the given state into the given line on the clock edge. `probe_state` shows the state of `probe_line` with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hold_req | input | 1 | Request from the system for the processor to release the bus |
| hold_ack | output | 1 | Bus released to the external master |
| snoop_valid | input | 1 | Snoop strobe from the external master |
| snoop_inv | input | 1 | 1: snoop comes from a write (invalidate); 0: from a read |
| snoop_line | input | IDX_W | Line index of the snoop |
| hitm_n | output | 1 | Low while a snooped modified line is pending write-back |
| ads_n | output | 1 | Address strobe for the write-back burst, active low |
| cache_n | output | 1 | Cacheable burst indication, active low, with the address strobe |
| wr | output | 1 | 1 for a write cycle |
| blast_n | output | 1 | Last beat of the burst, active low |
| rdy_n | input | 1 | Beat-ready from the memory system, active low |
| wb_line | output | IDX_W | Line being written back |
| wb_beat | output | BEAT_W | Current beat number |
| fill_en | input | 1 | Core-side write of a line state |
| fill_line | input | IDX_W | Line index for the fill |
| fill_state | input | 2 | State to write |
| probe_line | input | IDX_W | Line index to read |
| probe_state | output | 2 | State of the probed line |

## Verification
The bench starts by sending a strobe in the first cycle of a grant. A responder that samples too early would raise a false hit there and corrupt a modified line. It checks the exact cycle in which `hitm_n` falls and rises, since a pipeline that is one stage short or long moves both edges.

It holds `rdy_n` high in the middle of the burst. A sequencer that counts cycles instead of ready beats would then assert `blast_n` early. It also sends a second strobe while a write-back is pending. A design that keeps sampling would start a second lookup and disturb the first line's final state.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10,
    LS_MOD = 2'b11
  } line_st_t;

  typedef enum logic [2:0] {
    C_IDLE  = 3'd0,
    C_LOOK  = 3'd1,
    C_HITW  = 3'd2,
    C_WB    = 3'd3,
    C_REARM = 3'd4
  } ctrl_st_t;

  typedef enum logic [1:0] {
    B_IDLE = 2'd0,
    B_ADDR = 2'd1,
    B_DATA = 2'd2
  } burst_st_t;

endpackage

// File: rtl/snoop_line_table.sv
module snoop_line_table
  import snoop_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_line,
  input  line_st_t         upd_state,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_line,
  input  line_st_t         fill_state,
  input  logic [IDX_W-1:0] rd_a_line,
  output line_st_t         rd_a_state,
  input  logic [IDX_W-1:0] rd_b_line,
  output line_st_t         rd_b_state
);

  line_st_t st_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic     hit_upd, hit_fill, en;
    line_st_t nxt;

    always_comb begin
      hit_upd  = upd_en  && (upd_line  == IDX_W'(g));
      hit_fill = fill_en && (fill_line == IDX_W'(g));
      en       = hit_upd || hit_fill;
      // A snoop update has priority over a core fill
      nxt      = hit_upd ? upd_state : fill_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  st_q[g] <= LS_INV;
      else if (en) st_q[g] <= nxt;
    end
  end

  assign rd_a_state = st_q[rd_a_line];
  assign rd_b_state = st_q[rd_b_line];

endmodule

// File: rtl/snoop_burst_seq.sv
module snoop_burst_seq
  import snoop_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rdy_n,
  output logic              ads_n,
  output logic              cache_n,
  output logic              wr,
  output logic              blast_n,
  output logic [BEAT_W-1:0] beat,
  output logic              done
);

  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  burst_st_t         bst_q, bst_d;
  logic [BEAT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;
  logic              last;

  always_comb begin
    bst_d  = bst_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    last   = (cnt_q == LAST);
    done   = 1'b0;
    case (bst_q)
      B_IDLE: if (start) bst_d = B_ADDR;
      B_ADDR: begin
        bst_d  = B_DATA;
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
      B_DATA: if (!rdy_n) begin
        if (last) begin
          done  = 1'b1;
          bst_d = B_IDLE;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: bst_d = B_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bst_q <= B_IDLE;
    else        bst_q <= bst_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ads_n   = (bst_q != B_ADDR);
  assign cache_n = (bst_q != B_ADDR);
  assign wr      = (bst_q != B_IDLE);
  assign blast_n = !((bst_q == B_DATA) && last);
  assign beat    = cnt_q;

  // R6: the address strobe lasts one cycle
  assert_ads_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n |=> ads_n);

  // R7: a beat without ready holds the beat number
  assert_beat_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_q == B_DATA && rdy_n) |=> $stable(beat) && wr);

  // R7: the last beat accepted ends the burst
  assert_blast_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!blast_n && !rdy_n) |=> (blast_n && !wr));

endmodule

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_req,
  output logic             hold_ack,
  input  logic             snoop_valid,
  input  logic             snoop_inv,
  input  logic [IDX_W-1:0] snoop_line,
  output logic             hitm_n,
  output logic [IDX_W-1:0] cur_line,
  input  line_st_t         cur_state,
  output logic             upd_en,
  output line_st_t         upd_state,
  output logic             wb_start,
  input  logic             wb_done
);

  ctrl_st_t         st_q, st_d;
  logic             ack_q, ack_d, ack_prev_q;
  logic             hitm_q, hitm_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             inv_q, inv_d;
  logic             cap_en;
  line_st_t         after_snoop;

  assign after_snoop = inv_q ? LS_INV : LS_SHR;

  always_comb begin
    st_d      = st_q;
    ack_d     = ack_q;
    hitm_d    = hitm_q;
    idx_d     = snoop_line;
    inv_d     = snoop_inv;
    cap_en    = 1'b0;
    upd_en    = 1'b0;
    upd_state = after_snoop;
    wb_start  = 1'b0;
    case (st_q)
      C_IDLE: begin
        if (!ack_q) begin
          if (hold_req) ack_d = 1'b1;
        end else if (!hold_req) begin
          ack_d = 1'b0;
        end else if (snoop_valid && ack_prev_q) begin
          cap_en = 1'b1;
          st_d   = C_LOOK;
        end
      end
      C_LOOK: begin
        if (cur_state == LS_MOD) begin
          hitm_d = 1'b0;
          st_d   = C_HITW;
        end else begin
          upd_en = (cur_state != LS_INV);
          st_d   = C_IDLE;
        end
      end
      C_HITW: if (!hold_req) begin
        ack_d    = 1'b0;
        wb_start = 1'b1;
        st_d     = C_WB;
      end
      C_WB: if (wb_done) begin
        hitm_d = 1'b1;
        upd_en = 1'b1;
        st_d   = C_REARM;
      end
      C_REARM: begin
        ack_d = hold_req;
        st_d  = C_IDLE;
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= C_IDLE;
      ack_q      <= 1'b0;
      ack_prev_q <= 1'b0;
      hitm_q     <= 1'b1;
    end else begin
      st_q       <= st_d;
      ack_q      <= ack_d;
      ack_prev_q <= ack_q;
      hitm_q     <= hitm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      inv_q <= 1'b0;
    end else if (cap_en) begin
      idx_q <= idx_d;
      inv_q <= inv_d;
    end
  end

  assign hold_ack = ack_q;
  assign hitm_n   = hitm_q;
  assign cur_line = idx_q;

  // R4: a hit indication follows a granted strobe by two cycles
  assert_hitm_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hitm_q) |-> ($past(snoop_valid, 2) && $past(ack_q, 2)));

  // R8: the hit indication clears only after the burst completes
  assert_hitm_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hitm_q) |-> $past(wb_done));

  // R6: the grant is withdrawn for the whole write-back
  assert_ack_low_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == C_WB) |-> !ack_q);

  // R9: no grant while a modified line is pending
  assert_ack_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> (hitm_q && $past(hitm_q)));

endmodule

// File: rtl/snoop_wb_responder.sv
module snoop_wb_responder
  import snoop_pkg::*;
#(
  parameter int LINES = 16,
  parameter int BEATS = 4,
  localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_req,
  output logic              hold_ack,
  input  logic              snoop_valid,
  input  logic              snoop_inv,
  input  logic [IDX_W-1:0]  snoop_line,
  output logic              hitm_n,
  output logic              ads_n,
  output logic              cache_n,
  output logic              wr,
  output logic              blast_n,
  input  logic              rdy_n,
  output logic [IDX_W-1:0]  wb_line,
  output logic [BEAT_W-1:0] wb_beat,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_line,
  input  logic [1:0]        fill_state,
  input  logic [IDX_W-1:0]  probe_line,
  output logic [1:0]        probe_state
);

  logic rs1_q, rs2_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sync_n = rs2_q;

  logic [IDX_W-1:0] cur_line;
  line_st_t         cur_state, upd_state, probe_st;
  logic             upd_en, wb_start, wb_done;

  snoop_ctrl #(.LINES(LINES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .hold_req    (hold_req),
    .hold_ack    (hold_ack),
    .snoop_valid (snoop_valid),
    .snoop_inv   (snoop_inv),
    .snoop_line  (snoop_line),
    .hitm_n      (hitm_n),
    .cur_line    (cur_line),
    .cur_state   (cur_state),
    .upd_en      (upd_en),
    .upd_state   (upd_state),
    .wb_start    (wb_start),
    .wb_done     (wb_done)
  );

  snoop_line_table #(.LINES(LINES)) u_table (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .upd_en     (upd_en),
    .upd_line   (cur_line),
    .upd_state  (upd_state),
    .fill_en    (fill_en),
    .fill_line  (fill_line),
    .fill_state (line_st_t'(fill_state)),
    .rd_a_line  (cur_line),
    .rd_a_state (cur_state),
    .rd_b_line  (probe_line),
    .rd_b_state (probe_st)
  );

  snoop_burst_seq #(.BEATS(BEATS)) u_burst (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (wb_start),
    .rdy_n   (rdy_n),
    .ads_n   (ads_n),
    .cache_n (cache_n),
    .wr      (wr),
    .blast_n (blast_n),
    .beat    (wb_beat),
    .done    (wb_done)
  );

  assign wb_line     = cur_line;
  assign probe_state = probe_st;

  // R9: the bus is never granted while the burst drives it
  assert_no_grant_in_burst_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr |-> !hold_ack);

endmodule

// File: tb/snoop_wb_responder_test.sv
module snoop_wb_responder_test;

  localparam int LINES = 16;
  localparam int IDX_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             hold_req = 1'b0;
  logic             snoop_valid = 1'b0, snoop_inv = 1'b0;
  logic [IDX_W-1:0] snoop_line = '0;
  logic             rdy_n = 1'b1;
  logic             fill_en = 1'b0;
  logic [IDX_W-1:0] fill_line = '0, probe_line = '0;
  logic [1:0]       fill_state = 2'b00;
  logic             hold_ack, hitm_n, ads_n, cache_n, wr, blast_n;
  logic [IDX_W-1:0] wb_line;
  logic [1:0]       wb_beat, probe_state;

  always #2 clk = ~clk;

  snoop_wb_responder #(.LINES(LINES), .BEATS(4)) uut (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_ack(hold_ack),
    .snoop_valid(snoop_valid), .snoop_inv(snoop_inv), .snoop_line(snoop_line),
    .hitm_n(hitm_n), .ads_n(ads_n), .cache_n(cache_n), .wr(wr), .blast_n(blast_n),
    .rdy_n(rdy_n), .wb_line(wb_line), .wb_beat(wb_beat), .fill_en(fill_en),
    .fill_line(fill_line), .fill_state(fill_state), .probe_line(probe_line),
    .probe_state(probe_state)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 granted/owned, 1 lookup, 2 hit waiting,
  // 3 address, 4 data, 5 re-grant
  int         m_phase = 0, m_beat = 0, m_rs = 0, m_line = 0;
  bit         m_ack = 0, m_ackp = 0, m_hitm = 1, m_inv = 0, live = 0;
  logic [1:0] m_lines [LINES];

  initial for (int i = 0; i < LINES; i++) m_lines[i] = 2'b00;

  always @(posedge clk) begin
    bit oldack;
    live = 1'b1;
    if (!rst_n) m_rs = 0;
    else if (m_rs < 2) m_rs++;
    else begin
      oldack = m_ack;
      if (fill_en) m_lines[fill_line] = fill_state;
      case (m_phase)
        0: if (!m_ack) m_ack = hold_req;
           else if (!hold_req) m_ack = 0;
           else if (snoop_valid && m_ackp) begin
             m_line = int'(snoop_line); m_inv = snoop_inv; m_phase = 1;
           end
        1: if (m_lines[m_line] == 2'b11) begin m_hitm = 0; m_phase = 2; end
           else begin
             if (m_lines[m_line] != 2'b00) m_lines[m_line] = m_inv ? 2'b00 : 2'b01;
             m_phase = 0;
           end
        2: if (!hold_req) begin m_ack = 0; m_phase = 3; end
        3: begin m_phase = 4; m_beat = 0; end
        4: if (!rdy_n) begin
             if (m_beat == 3) begin
               m_hitm = 1; m_lines[m_line] = m_inv ? 2'b00 : 2'b01; m_phase = 5;
             end else m_beat++;
           end
        default: begin m_ack = hold_req; m_phase = 0; end
      endcase
      m_ackp = oldack;
    end
  end

  always @(negedge clk) if (live && !finished) begin
    chk(hold_ack == m_ack, "R2 hold_ack", hold_ack, m_ack);
    chk(hitm_n == m_hitm, "R4 hitm_n", hitm_n, m_hitm);
    chk(ads_n == (m_phase != 3) && cache_n == (m_phase != 3), "R6 ads_n", ads_n, m_phase != 3);
    chk(wr == (m_phase == 3 || m_phase == 4), "R7 wr", wr, m_phase == 3 || m_phase == 4);
    chk(blast_n == !(m_phase == 4 && m_beat == 3), "R7 blast_n", blast_n, !(m_phase == 4 && m_beat == 3));
    if (m_phase == 4) chk(wb_beat == m_beat[1:0], "R7 wb_beat", wb_beat, m_beat);
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic probe(input int line, input int exp, input string tag);
    probe_line = IDX_W'(line);
    #0.1;
    chk(probe_state == 2'(exp), tag, probe_state, exp);
  endtask

  task automatic fill(input int line, input int st);
    fill_en = 1; fill_line = IDX_W'(line); fill_state = 2'(st);
    step(); fill_en = 0;
  endtask

  task automatic strobe(input int line, input bit inv);
    snoop_valid = 1; snoop_line = IDX_W'(line); snoop_inv = inv;
    step(); snoop_valid = 0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    step(4);
    // R1 reset state
    chk(hold_ack == 0 && hitm_n == 1 && ads_n == 1 && blast_n == 1 && wr == 0,
        "R1 reset outputs", {hold_ack, hitm_n, ads_n, blast_n, wr}, 5'b01110);
    probe(7, 0, "R1 line invalid after reset");

    // R11 fills
    fill(0, 3); fill(1, 2); fill(2, 1); fill(3, 3); fill(5, 3);
    probe(1, 2, "R11 fill exclusive");
    probe(0, 3, "R11 fill modified");

    // R3 strobe while not granted is ignored
    strobe(0, 0);
    step(2);
    chk(hitm_n == 1, "R3 strobe without grant", hitm_n, 1);

    // R2 grant one cycle after request
    hold_req = 1;
    step();
    chk(hold_ack == 1, "R2 grant rises", hold_ack, 1);
    // R3 strobe in the first granted cycle is ignored
    strobe(0, 0);
    step(2);
    chk(hitm_n == 1, "R3 first-cycle strobe ignored", hitm_n, 1);
    probe(0, 3, "R3 line untouched");

    // R5 non-modified lines
    strobe(1, 0); step(2);
    chk(hitm_n == 1 && hold_ack == 1, "R5 exclusive hit no hitm", hitm_n, 1);
    probe(1, 1, "R5 exclusive to shared");
    strobe(2, 1); step(2);
    probe(2, 0, "R5 shared invalidated");
    strobe(9, 1); step(2);
    chk(hitm_n == 1 && hold_ack == 1, "R5 miss keeps grant", hold_ack, 1);

    // R4 modified hit timing
    snoop_valid = 1; snoop_line = 0; snoop_inv = 0;
    step(); snoop_valid = 0;
    chk(hitm_n == 1, "R4 hitm not yet", hitm_n, 1);
    step();
    chk(hitm_n == 0, "R4 hitm low two cycles after strobe", hitm_n, 0);
    // R8 strobe during pending hit is ignored
    strobe(3, 1);
    step(2);
    chk(hold_ack == 1, "R6 grant held until request drops", hold_ack, 1);

    // R6 take bus back
    hold_req = 0;
    step();
    chk(hold_ack == 0 && ads_n == 0 && cache_n == 0 && wr == 1, "R6 address cycle",
        {hold_ack, ads_n, cache_n, wr}, 4'b0001);
    hold_req = 1;
    step();
    chk(ads_n == 1 && wb_beat == 0 && blast_n == 1, "R7 first beat", wb_beat, 0);
    step();
    chk(wb_beat == 0 && blast_n == 1, "R7 stall holds beat", wb_beat, 0);
    rdy_n = 0;
    step(3);
    chk(wb_beat == 3 && blast_n == 0, "R7 blast on fourth beat", blast_n, 0);
    chk(wb_line == 0, "R7 write-back line", wb_line, 0);
    step();
    rdy_n = 1;
    chk(hitm_n == 1 && hold_ack == 0, "R8 hitm restored", hitm_n, 1);
    probe(0, 1, "R10 read snoop leaves shared");
    probe(3, 3, "R8 ignored strobe left line modified");
    step();
    chk(hold_ack == 1, "R9 grant returns", hold_ack, 1);

    // R10 invalidating write-back with ready every cycle
    step();
    rdy_n = 0;
    strobe(5, 1); step();
    chk(hitm_n == 0, "R4 second hit", hitm_n, 0);
    hold_req = 0;
    step(6);
    chk(hitm_n == 1, "R8 second restore", hitm_n, 1);
    probe(5, 0, "R10 write snoop invalidates");
    rdy_n = 1;
    step();
    chk(hold_ack == 0, "R9 no grant without request", hold_ack, 0);
    hold_req = 1; step(3);
    hold_req = 0; step();
    chk(hold_ack == 0, "R2 grant falls", hold_ack, 0);
    step(3);
    finish_run();
  end

endmodule